// File: doc/BRIEF.md
# Dithered Switching Timebase with Light-Load Foldback

This block is the digital timebase of a flyback PWM controller. It emits a one-clock strobe at the start of every switching cycle. It also outputs a phase count that runs from zero to the cycle length minus one, and the length in clocks of the cycle now running. The on-time logic downstream uses the phase count to place its gate edges. Because foldback only lengthens the cycle, the time after the on-pulse grows and the on-pulse itself is never cut short.

The nominal length comes from a configuration input, which is set by the frequency-programming logic. When dithering is enabled, a triangle counter adds a signed offset to the nominal length. The counter is stepped by a prescaled tick, so the switching frequency sweeps slowly above and below its nominal value. A digitised feedback code adds a second term. When the code drops below an entry threshold, the cycle is stretched in proportion to how far the code has dropped. Once the code is a fixed span below the entry threshold, the cycle length reaches the longest allowed value, which sets the floor frequency. A new length takes effect only at a cycle boundary.

With the default parameters and a 50 MHz clock, the nominal length is 769 clocks (65 kHz). The dither swing is ±48 clocks, and one full sweep takes about 4.4 ms. The floor is 2272 clocks, just above 22 kHz. Lengths below 458 clocks are raised to 458 (109 kHz).

Top module: `hop_osc_timebase`

## Requirements
- R1: After a synchronous active-low reset, `cyc_start`, `phase` and `cyc_len` are all zero.
- R2: The first `cyc_start` pulse comes one clock after `en` is first seen high. While `en` is low, `cyc_start`, `phase` and `cyc_len` are all zero from the next clock onward.
- R3: While running, `cyc_start` is high for exactly one clock per cycle. `phase` is 0 in that clock and counts up by one each clock to `cyc_len`-1, and the next strobe follows `cyc_len` clocks after the previous one.
- R4: `cyc_len` changes only in a clock where `cyc_start` is high. A change of feedback or dither in the middle of a cycle does not alter the length of that cycle.
- R5: With feedback code >= FB_ENTRY, `cyc_len` equals the dithered base: `nom_period` + offset, clamped to [MIN_PERIOD, MAX_PERIOD].
- R6: With feedback code d below FB_ENTRY, where 0 < d < 2^SPAN_LOG2, `cyc_len` = base + floor((MAX_PERIOD - base) * d / 2^SPAN_LOG2). The length therefore grows linearly as the code drops.
- R7: With feedback code <= FB_ENTRY - 2^SPAN_LOG2, `cyc_len` equals MAX_PERIOD. `cyc_len` never exceeds MAX_PERIOD.
- R8: Before foldback is applied, a dithered base below MIN_PERIOD is raised to MIN_PERIOD and one above MAX_PERIOD is lowered to MAX_PERIOD.
- R9: With `dither_en` high, the offset is DITHER_STEP times a position that moves by one every TICK_DIV clocks. The position climbs from 0 to +DITHER_AMP, turns and falls to -DITHER_AMP, then turns again, so one sweep takes 4*DITHER_AMP ticks.
- R10: With `dither_en` low, the dither position and its prescaler are held at zero. Cycles latched while dither is off then have exactly the undithered length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Run enable for the cycle counter |
| dither_en | input | 1 | Enables the triangle dither |
| nom_period | input | PW | Nominal cycle length in clocks |
| fb_code | input | FBW | Unsigned digitised feedback level |
| cyc_start | output | 1 | One-clock strobe at the start of each cycle |
| phase | output | PW | Clock count within the current cycle |
| cyc_len | output | PW | Length of the current cycle in clocks |

## Verification
A behavioural model in the bench is compared with the outputs on every clock. Directed feedback codes are chosen to separate the regions of the length calculation. A code at the entry threshold gives no stretch, and a code just below it shows the first linear step. A code in the middle of the span shows that the term is proportional. Codes at and below the ending threshold show the floor clamp. A feedback change in the middle of a cycle, with a long target, separates latching at the boundary from immediate use. Nominal values outside the range exercise the base clamp. A long dithered run must reach both extremes of the swing, and switching dither off must restore the exact nominal length.

// File: rtl/hop_osc_pkg.sv
package hop_osc_pkg;

  // Nominal length plus dither offset, limited to the legal period range.
  function automatic int dither_base(int nom, int offs, int lo, int hi);
    int b;
    b = nom + offs;
    if (b < lo) b = lo;
    if (b > hi) b = hi;
    return b;
  endfunction

  // Off-time extension: linear across the span below the entry code,
  // saturating at the floor-frequency length.
  function automatic int foldback_len(int base, int fb, int entry,
                                      int span_log2, int hi);
    int depth;
    int res;
    depth = entry - fb;
    if (depth <= 0)
      res = base;
    else if (depth >= (1 << span_log2))
      res = hi;
    else
      res = base + (((hi - base) * depth) >>> span_log2);
    return res;
  endfunction

endpackage

// File: rtl/hop_prescale.sv
module hop_prescale #(
  parameter int DIV = 3438
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = enable && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable)
      cnt <= '0;
    else if (tick)
      cnt <= '0;
    else
      cnt <= cnt + CW'(1);
  end

  // R10: prescaler is cleared while dither is off
  a_r10_prescale_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt == '0));

endmodule

// File: rtl/hop_triangle.sv
module hop_triangle #(
  parameter int AMP   = 16,
  parameter int POS_W = $clog2(AMP + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    tick,
  output logic signed [POS_W-1:0] pos,
  output logic                    climbing
);
  localparam logic signed [POS_W-1:0] PMAX = POS_W'(AMP);
  localparam logic signed [POS_W-1:0] PMIN = -PMAX;
  localparam logic signed [POS_W-1:0] NEAR_TOP = POS_W'(AMP - 1);
  localparam logic signed [POS_W-1:0] NEAR_BOT = -NEAR_TOP;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      pos      <= '0;
      climbing <= 1'b1;
    end else if (tick) begin
      if (climbing) begin
        pos <= pos + POS_W'(1);
        if (pos == NEAR_TOP) climbing <= 1'b0;
      end else begin
        pos <= pos - POS_W'(1);
        if (pos == NEAR_BOT) climbing <= 1'b1;
      end
    end
  end

  // R9: position stays within the swing
  a_r9_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (pos <= PMAX) && (pos >= PMIN));
  // R9: position moves only on a prescaled tick
  a_r9_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !tick) |=> $stable(pos));
  // R10: dither off forces the position to zero
  a_r10_pos_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (pos == '0));

endmodule

// File: rtl/hop_period_calc.sv
module hop_period_calc
  import hop_osc_pkg::*;
#(
  parameter int PW         = 16,
  parameter int FBW        = 8,
  parameter int POS_W      = 6,
  parameter int FB_ENTRY   = 107,
  parameter int SPAN_LOG2  = 4,
  parameter int MIN_PERIOD = 458,
  parameter int MAX_PERIOD = 2272,
  parameter int STEP       = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PW-1:0]           nom,
  input  logic signed [POS_W-1:0] pos,
  input  logic [FBW-1:0]          fb,
  output logic [PW-1:0]           base_len,
  output logic [PW-1:0]           next_len
);
  int base_i;
  int fold_i;

  always_comb begin
    base_i   = dither_base(int'(nom), int'(pos) * STEP, MIN_PERIOD, MAX_PERIOD);
    fold_i   = foldback_len(base_i, int'(fb), FB_ENTRY, SPAN_LOG2, MAX_PERIOD);
    base_len = PW'(base_i);
    next_len = PW'(fold_i);
  end

  // R6: foldback only ever lengthens the cycle
  a_r6_never_shorter: assert property (@(posedge clk) disable iff (!rst_n)
    next_len >= base_len);
  // R7: never slower than the floor frequency
  a_r7_floor_freq: assert property (@(posedge clk) disable iff (!rst_n)
    next_len <= PW'(MAX_PERIOD));

endmodule

// File: rtl/hop_cycle_ctr.sv
module hop_cycle_ctr #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] next_len,
  output logic          cyc_start,
  output logic [PW-1:0] phase,
  output logic [PW-1:0] cyc_len,
  output logic          running,
  output logic          boundary
);
  assign boundary = !running || (phase == cyc_len - PW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cyc_start <= 1'b0;
      phase     <= '0;
      cyc_len   <= '0;
      running   <= 1'b0;
    end else if (boundary) begin
      cyc_start <= 1'b1;
      phase     <= '0;
      cyc_len   <= next_len;
      running   <= 1'b1;
    end else begin
      cyc_start <= 1'b0;
      phase     <= phase + PW'(1);
    end
  end

  // R3: phase stays inside the current cycle
  a_r3_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (phase < cyc_len));
  // R4: length only moves at a strobe
  a_r4_len_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !cyc_start) |-> $stable(cyc_len));

endmodule

// File: rtl/hop_osc_timebase.sv
module hop_osc_timebase #(
  parameter int PW          = 16,
  parameter int FBW         = 8,
  parameter int FB_ENTRY    = 107,
  parameter int SPAN_LOG2   = 4,
  parameter int MIN_PERIOD  = 458,
  parameter int MAX_PERIOD  = 2272,
  parameter int DITHER_AMP  = 16,
  parameter int DITHER_STEP = 3,
  parameter int TICK_DIV    = 3438
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           dither_en,
  input  logic [PW-1:0]  nom_period,
  input  logic [FBW-1:0] fb_code,
  output logic           cyc_start,
  output logic [PW-1:0]  phase,
  output logic [PW-1:0]  cyc_len
);
  localparam int POS_W = $clog2(DITHER_AMP + 1) + 1;

  logic                    dither_tick;
  logic signed [POS_W-1:0] dither_pos;
  logic                    dither_climbing;
  logic [PW-1:0]           base_len;
  logic [PW-1:0]           next_len;
  logic                    running;
  logic                    boundary;

  hop_prescale #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .enable(dither_en), .tick(dither_tick)
  );

  hop_triangle #(.AMP(DITHER_AMP), .POS_W(POS_W)) u_tri (
    .clk(clk), .rst_n(rst_n), .enable(dither_en), .tick(dither_tick),
    .pos(dither_pos), .climbing(dither_climbing)
  );

  hop_period_calc #(
    .PW(PW), .FBW(FBW), .POS_W(POS_W), .FB_ENTRY(FB_ENTRY),
    .SPAN_LOG2(SPAN_LOG2), .MIN_PERIOD(MIN_PERIOD),
    .MAX_PERIOD(MAX_PERIOD), .STEP(DITHER_STEP)
  ) u_calc (
    .clk(clk), .rst_n(rst_n), .nom(nom_period), .pos(dither_pos),
    .fb(fb_code), .base_len(base_len), .next_len(next_len)
  );

  hop_cycle_ctr #(.PW(PW)) u_cyc (
    .clk(clk), .rst_n(rst_n), .en(en), .next_len(next_len),
    .cyc_start(cyc_start), .phase(phase), .cyc_len(cyc_len),
    .running(running), .boundary(boundary)
  );

  // R2: first strobe one clock after enable rises
  a_r2_first_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |=> cyc_start);
  // R2: idle outputs while disabled
  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!cyc_start && phase == '0 && cyc_len == '0));
  // R8: running length lies within the legal range
  a_r8_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cyc_len >= PW'(MIN_PERIOD) && cyc_len <= PW'(MAX_PERIOD)));
  // R3: a strobe only ever follows a boundary
  a_r3_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !boundary) |=> !cyc_start);

endmodule

// File: tb/tb_hop_osc_timebase.sv
`timescale 1ns/1ps
module tb_hop_osc_timebase;
  localparam int PW = 12, FBW = 8, ENTRY = 100, SPAN_LOG2 = 4;
  localparam int MINP = 20, MAXP = 200, AMP = 4, STEP = 3, DIV = 97;
  localparam int SPAN = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, en, dither_en;
  logic [PW-1:0] nom_period;
  logic [FBW-1:0] fb_code;
  logic cyc_start;
  logic [PW-1:0] phase, cyc_len;

  hop_osc_timebase #(
    .PW(PW), .FBW(FBW), .FB_ENTRY(ENTRY), .SPAN_LOG2(SPAN_LOG2),
    .MIN_PERIOD(MINP), .MAX_PERIOD(MAXP), .DITHER_AMP(AMP),
    .DITHER_STEP(STEP), .TICK_DIV(DIV)
  ) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .dither_en(dither_en),
    .nom_period(nom_period), .fb_code(fb_code),
    .cyc_start(cyc_start), .phase(phase), .cyc_len(cyc_len)
  );

  int checks = 0, errors = 0;
  bit cmp_on = 0;

  // behavioural reference state
  int m_run = 0, m_phase = 0, m_len = 0, m_start = 0;
  int m_pos = 0, m_up = 1, m_pre = 0;

  function automatic int ref_len(int nom_i, int pos_i, int fb_i);
    int target, below;
    target = nom_i + STEP * pos_i;
    target = (target < MINP) ? MINP : ((target > MAXP) ? MAXP : target);
    below = ENTRY - fb_i;
    if (below <= 0) return target;
    if (below >= SPAN) return MAXP;
    return target + ((MAXP - target) * below) / SPAN;
  endfunction

  always @(posedge clk) begin
    int new_len;
    new_len = ref_len(int'(nom_period), m_pos, int'(fb_code));
    if (!rst_n) begin
      m_run = 0; m_phase = 0; m_len = 0; m_start = 0;
      m_pos = 0; m_up = 1; m_pre = 0;
    end else begin
      if (!en) begin
        m_run = 0; m_phase = 0; m_len = 0; m_start = 0;
      end else if (m_run == 0 || m_phase == m_len - 1) begin
        m_start = 1; m_phase = 0; m_len = new_len; m_run = 1;
      end else begin
        m_start = 0; m_phase = m_phase + 1;
      end
      if (!dither_en) begin
        m_pos = 0; m_up = 1; m_pre = 0;
      end else if (m_pre == DIV - 1) begin
        m_pre = 0;
        if (m_up == 1) begin
          m_pos = m_pos + 1;
          if (m_pos == AMP) m_up = 0;
        end else begin
          m_pos = m_pos - 1;
          if (m_pos == -AMP) m_up = 1;
        end
      end else begin
        m_pre = m_pre + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(int'(cyc_start) == m_start, "R3 strobe vs model", int'(cyc_start), m_start);
      chk(int'(phase) == m_phase, "R3 phase vs model", int'(phase), m_phase);
      chk(int'(cyc_len) == m_len, "R4 length vs model", int'(cyc_len), m_len);
    end
  end

  task automatic wait_strobe(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!cyc_start && n < 1000);
  endtask

  task automatic latch_check(input int fbv, input int exp, input string tag);
    int n;
    fb_code = FBW'(fbv);
    wait_strobe(n);
    chk(int'(cyc_len) == exp, tag, int'(cyc_len), exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, lo, hi;
    bit held;
    rst_n = 0; en = 0; dither_en = 0; nom_period = PW'(60); fb_code = 8'd255;
    repeat (4) @(negedge clk);
    rst_n = 1;
    cmp_on = 1;
    @(negedge clk);
    // R1: reset state
    chk(cyc_start == 0 && phase == 0 && cyc_len == 0, "R1 reset outputs zero",
        int'(cyc_len) + int'(phase) + int'(cyc_start), 0);

    // R2: first strobe one clock after enable
    en = 1;
    @(negedge clk);
    chk(cyc_start == 1, "R2 first strobe", int'(cyc_start), 1);
    chk(int'(cyc_len) == 60, "R5 no foldback above entry", int'(cyc_len), 60);
    wait_strobe(n);
    chk(n == 60, "R3 strobe spacing", n, 60);

    latch_check(ENTRY, 60, "R5 at entry code");
    latch_check(99, 68, "R6 one code below entry");
    latch_check(92, 130, "R6 mid span");
    latch_check(85, 191, "R6 last linear code");
    latch_check(84, MAXP, "R7 at ending code");
    latch_check(0, MAXP, "R7 far below");
    wait_strobe(n);
    chk(n == MAXP, "R7 floor frequency spacing", n, MAXP);

    // R4: mid-cycle feedback change does not touch the running cycle
    fb_code = 8'd255;
    wait_strobe(n);
    repeat (10) @(negedge clk);
    fb_code = 8'd0;
    held = 1;
    do begin
      @(negedge clk);
      if (!cyc_start && cyc_len != 60) held = 0;
    end while (!cyc_start);
    chk(held, "R4 length held mid cycle", int'(held), 1);
    chk(int'(cyc_len) == MAXP, "R4 new length at boundary", int'(cyc_len), MAXP);

    // R8: clamps on the base
    fb_code = 8'd255;
    nom_period = PW'(10);
    wait_strobe(n);
    wait_strobe(n);
    chk(int'(cyc_len) == MINP, "R8 raised to minimum", int'(cyc_len), MINP);
    nom_period = PW'(250);
    wait_strobe(n);
    chk(int'(cyc_len) == MAXP, "R8 lowered to maximum", int'(cyc_len), MAXP);
    nom_period = PW'(60);
    wait_strobe(n);

    // R9: dither reaches both extremes
    dither_en = 1;
    lo = 1000; hi = 0;
    repeat (8000) begin
      @(negedge clk);
      if (cyc_start) begin
        if (int'(cyc_len) < lo) lo = int'(cyc_len);
        if (int'(cyc_len) > hi) hi = int'(cyc_len);
      end
    end
    chk(hi == 60 + STEP * AMP, "R9 upper dither extreme", hi, 60 + STEP * AMP);
    chk(lo == 60 - STEP * AMP, "R9 lower dither extreme", lo, 60 - STEP * AMP);

    // R10: dither off restores exact nominal
    dither_en = 0;
    wait_strobe(n);
    wait_strobe(n);
    chk(int'(cyc_len) == 60, "R10 undithered length", int'(cyc_len), 60);
    wait_strobe(n);
    chk(n == 60, "R10 undithered spacing", n, 60);

    // R2: disable returns to idle
    en = 0;
    @(negedge clk);
    chk(cyc_start == 0 && phase == 0 && cyc_len == 0, "R2 idle after disable",
        int'(cyc_len) + int'(phase), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule